// File: doc/BRIEF.md
# Dual-Button Long-Press Reset Generator

This block watches two active-low push buttons and produces an active-low reset when both are held down together for long enough. Before use, both buttons pass through a two-stage synchronizer. A hold counter runs only while both synchronized buttons are low. It restarts from zero on every new joint press, so a short or interrupted press never produces a reset.

A static select input chooses the hold time. With select low, the block uses the normal hold. With select high, it uses either a long hold or a near-zero test detection delay, as fixed at build time. The reset then ends in one of two ways, also fixed at build time:

- **Fixed mode:** the reset lasts a set pulse length, whatever the buttons do. After the pulse, the block waits for a release before it can trigger again.
- **Level mode:** the reset lasts until either button goes high.

All durations are given in microseconds and converted to cycle counts from a clock-frequency parameter. After the internal reset is released, a start-up delay runs before any press is evaluated. This covers buttons that are already held at power-up.

Top module: `dual_press_reset`

## Requirements
- R1: After `rst` is released with both buttons high, `rst_out_n` is 1 and stays 1 while no joint press happens.
- R2: If either button goes high before the hold time ends, no reset occurs. The next joint press times its hold from its own start.
- R3: With `sel_alt` = 0, `rst_out_n` goes to 0 about HOLD_SHORT_US of clock time after both buttons go low. The added latency is a few cycles: two synchronizer stages and one state register.
- R4: With `sel_alt` = 1 and ALT_IS_TEST = 0, the hold time is HOLD_LONG_US.
- R5: With `sel_alt` = 1 and ALT_IS_TEST = 1, the reset follows a joint press after DETECT_US plus the same few cycles of latency.
- R6: With LEVEL_END = 0, `rst_out_n` stays 0 for PULSE_US and then returns to 1. Releasing the buttons during the pulse does not shorten it.
- R7: With LEVEL_END = 1, `rst_out_n` stays 0 for as long as both buttons remain low. It returns to 1 within three cycles after either button goes high.
- R8: After `rst` is released, no press is evaluated until STARTUP_US has passed. With both buttons held from power-up, the reset comes after the start-up delay plus the hold time.
- R9: After a fixed-length pulse, no further reset occurs while both buttons stay low. A new reset needs at least one button to go high and then both to go low again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock at CLK_HZ |
| rst | input | 1 | Synchronous active-high internal reset |
| btn_a_n | input | 1 | First push button, active low, asynchronous |
| btn_b_n | input | 1 | Second push button, active low, asynchronous |
| sel_alt | input | 1 | Static hold select: 0 = normal hold, 1 = alternate hold |
| rst_out_n | output | 1 | Registered reset output, active low |

## Verification
The bench sets CLK_HZ to 1 MHz so that one microsecond equals one cycle. It shrinks the durations to tens of cycles: start-up 10, short hold 40, long hold 70, pulse 20, detect 3. This makes every timing window, abort, re-press and start-up case reachable in a few hundred cycles.

Two instances are built:
- **`u_dut`:** long alternate hold with fixed pulses. It covers the hold selection, pulse length, repeat lockout and start-up cases.
- **`u_dut_tst`:** test alternate hold with level-ended reset. It covers the short detection path and release-ended reset.

Each check samples a few cycles inside or outside the expected edge, so the synchronizer latency does not blur the result.

// File: rtl/dpr_pkg.sv
package dpr_pkg;

  typedef enum logic [2:0] {
    ST_BOOT,
    ST_IDLE,
    ST_HOLD,
    ST_PULSE,
    ST_LATCH
  } dpr_state_e;

  function automatic longint us_to_cyc(input longint clk_hz, input longint us);
    return (clk_hz * us) / 64'd1_000_000;
  endfunction

endpackage

// File: rtl/dpr_sync.sv
module dpr_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);

  for (genvar b = 0; b < W; b++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk) begin
      if (rst) chain <= '1;
      else     chain <= {chain[STAGES-2:0], din[b]};
    end
    assign dout[b] = chain[STAGES-1];
  end

endmodule

// File: rtl/dpr_timer.sv
module dpr_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  output logic [CW-1:0] cnt
);

  always_ff @(posedge clk) begin
    if (rst || clr)  cnt <= '0;
    else if (~&cnt)  cnt <= cnt + 1'b1;
  end

  a_r2_restart_zero: assert property (@(posedge clk) disable iff (rst)
    clr |=> (cnt == '0));

endmodule

// File: rtl/dpr_ctrl.sv
module dpr_ctrl
  import dpr_pkg::*;
#(
  parameter int CW          = 8,
  parameter int STARTUP_CYC = 10,
  parameter int HOLD_A_CYC  = 40,
  parameter int HOLD_B_CYC  = 70,
  parameter int PULSE_CYC   = 20,
  parameter int LEVEL_END   = 0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          both_low,
  input  logic          sel_alt,
  input  logic [CW-1:0] cnt,
  output logic          restart,
  output logic          rst_out_n
);

  localparam logic [CW-1:0] T_START = CW'(STARTUP_CYC);
  localparam logic [CW-1:0] T_A     = CW'(HOLD_A_CYC);
  localparam logic [CW-1:0] T_B     = CW'(HOLD_B_CYC);
  localparam logic [CW-1:0] T_PULSE = CW'(PULSE_CYC);

  dpr_state_e st, nxt, pulse_next;
  logic       pulse_exit;
  logic [CW-1:0] hold_tgt;
  logic       out_q;

  assign hold_tgt = sel_alt ? T_B : T_A;

  if (LEVEL_END != 0) begin : g_level
    assign pulse_exit = ~both_low;
    assign pulse_next = ST_IDLE;

    a_r7_level_release: assert property (@(posedge clk) disable iff (rst)
      (st == ST_PULSE && !both_low) |=> rst_out_n);
  end else begin : g_fixed
    assign pulse_exit = (cnt == T_PULSE);
    assign pulse_next = ST_LATCH;

    a_r6_pulse_holds: assert property (@(posedge clk) disable iff (rst)
      (st == ST_PULSE && cnt < T_PULSE) |=> !rst_out_n);
  end

  always_comb begin
    nxt = st;
    unique case (st)
      ST_BOOT:  if (cnt == T_START) nxt = ST_IDLE;
      ST_IDLE:  if (both_low) nxt = ST_HOLD;
      ST_HOLD: begin
        if (!both_low)             nxt = ST_IDLE;
        else if (cnt == hold_tgt)  nxt = ST_PULSE;
      end
      ST_PULSE: if (pulse_exit) nxt = pulse_next;
      ST_LATCH: if (!both_low) nxt = ST_IDLE;
      default:  nxt = ST_IDLE;
    endcase
  end

  assign restart = (nxt != st);

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= ST_BOOT;
      out_q <= 1'b1;
    end else begin
      st    <= nxt;
      out_q <= (nxt != ST_PULSE);
    end
  end

  assign rst_out_n = out_q;

  a_r2_press_held: assert property (@(posedge clk) disable iff (rst)
    $fell(rst_out_n) |-> $past(both_low));

  a_r3_hold_reached: assert property (@(posedge clk) disable iff (rst)
    $fell(rst_out_n) |-> ($past(cnt) == $past(hold_tgt)));

  a_r8_boot_quiet: assert property (@(posedge clk) disable iff (rst)
    (st == ST_BOOT) |-> rst_out_n);

  a_r9_no_repeat: assert property (@(posedge clk) disable iff (rst)
    (st == ST_LATCH) |=> rst_out_n);

endmodule

// File: rtl/dual_press_reset.sv
module dual_press_reset
  import dpr_pkg::*;
#(
  parameter int CLK_HZ        = 100_000_000,
  parameter int STARTUP_US    = 300,
  parameter int HOLD_SHORT_US = 7_500_000,
  parameter int HOLD_LONG_US  = 12_500_000,
  parameter int PULSE_US      = 80_000,
  parameter int DETECT_US     = 150,
  parameter int ALT_IS_TEST   = 0,
  parameter int LEVEL_END     = 0
) (
  input  logic clk,
  input  logic rst,
  input  logic btn_a_n,
  input  logic btn_b_n,
  input  logic sel_alt,
  output logic rst_out_n
);

  localparam longint C_START = us_to_cyc(CLK_HZ, STARTUP_US);
  localparam longint C_SHORT = us_to_cyc(CLK_HZ, HOLD_SHORT_US);
  localparam longint C_ALT   = (ALT_IS_TEST != 0) ? us_to_cyc(CLK_HZ, DETECT_US)
                                                  : us_to_cyc(CLK_HZ, HOLD_LONG_US);
  localparam longint C_PULSE = us_to_cyc(CLK_HZ, PULSE_US);
  localparam longint C_M1    = (C_START > C_SHORT) ? C_START : C_SHORT;
  localparam longint C_M2    = (C_ALT > C_PULSE) ? C_ALT : C_PULSE;
  localparam longint C_MAX   = (C_M1 > C_M2) ? C_M1 : C_M2;
  localparam int     CW      = $clog2(C_MAX + 2) + 1;

  logic [1:0]    btn_s;
  logic          both_low;
  logic          restart;
  logic [CW-1:0] cnt;

  dpr_sync #(.W(2), .STAGES(2)) u_sync (
    .clk  (clk),
    .rst  (rst),
    .din  ({btn_b_n, btn_a_n}),
    .dout (btn_s)
  );

  assign both_low = ~btn_s[0] & ~btn_s[1];

  dpr_timer #(.CW(CW)) u_timer (
    .clk (clk),
    .rst (rst),
    .clr (restart),
    .cnt (cnt)
  );

  dpr_ctrl #(
    .CW          (CW),
    .STARTUP_CYC (int'(C_START)),
    .HOLD_A_CYC  (int'(C_SHORT)),
    .HOLD_B_CYC  (int'(C_ALT)),
    .PULSE_CYC   (int'(C_PULSE)),
    .LEVEL_END   (LEVEL_END)
  ) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .both_low  (both_low),
    .sel_alt   (sel_alt),
    .cnt       (cnt),
    .restart   (restart),
    .rst_out_n (rst_out_n)
  );

  a_r1_reset_idle: assert property (@(posedge clk)
    $past(rst) |-> rst_out_n);

endmodule

// File: tb/dual_press_reset_tb.sv
module dual_press_reset_tb;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic a_n = 1'b1, b_n = 1'b1, sel = 1'b0;
  logic ta_n = 1'b1, tb_n = 1'b1, tsel = 1'b0;
  logic out_n, tout_n;
  int   n_checks = 0;
  int   n_errors = 0;

  always #5 clk = ~clk;

  dual_press_reset #(
    .CLK_HZ(1_000_000), .STARTUP_US(10), .HOLD_SHORT_US(40), .HOLD_LONG_US(70),
    .PULSE_US(20), .DETECT_US(3), .ALT_IS_TEST(0), .LEVEL_END(0)
  ) u_dut (
    .clk(clk), .rst(rst), .btn_a_n(a_n), .btn_b_n(b_n), .sel_alt(sel), .rst_out_n(out_n)
  );

  dual_press_reset #(
    .CLK_HZ(1_000_000), .STARTUP_US(10), .HOLD_SHORT_US(40), .HOLD_LONG_US(70),
    .PULSE_US(20), .DETECT_US(3), .ALT_IS_TEST(1), .LEVEL_END(1)
  ) u_dut_tst (
    .clk(clk), .rst(rst), .btn_a_n(ta_n), .btn_b_n(tb_n), .sel_alt(tsel), .rst_out_n(tout_n)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input logic act, input logic exp, input string req);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1; a_n = 1'b1; b_n = 1'b1; ta_n = 1'b1; tb_n = 1'b1;
    step(3);
    rst = 1'b0;
    step(15);
  endtask

  task automatic t_r1_idle();
    do_reset();
    check(out_n, 1'b1, "R1 idle after reset");
    check(tout_n, 1'b1, "R1 idle after reset (test inst)");
    step(100);
    check(out_n, 1'b1, "R1 stays high with no press");
  endtask

  task automatic t_r3_short();
    do_reset(); sel = 1'b0;
    a_n = 1'b0; b_n = 1'b0;
    step(35); check(out_n, 1'b1, "R3 before short hold");
    step(15); check(out_n, 1'b0, "R3 after short hold");
    step(30); a_n = 1'b1; b_n = 1'b1; step(10);
  endtask

  task automatic t_r4_long();
    do_reset(); sel = 1'b1;
    a_n = 1'b0; b_n = 1'b0;
    step(65); check(out_n, 1'b1, "R4 before long hold");
    step(15); check(out_n, 1'b0, "R4 after long hold");
    step(30); a_n = 1'b1; b_n = 1'b1; sel = 1'b0; step(10);
  endtask

  task automatic t_r2_abort();
    do_reset(); sel = 1'b0;
    a_n = 1'b0; b_n = 1'b0; step(30);
    b_n = 1'b1; step(60);
    check(out_n, 1'b1, "R2 early release gives no reset");
    a_n = 1'b0; b_n = 1'b0; step(20);
    a_n = 1'b1; step(10);
    a_n = 1'b0;
    step(35); check(out_n, 1'b1, "R2 hold restarts on new press");
    step(15); check(out_n, 1'b0, "R2 reset after full re-press");
    step(30); a_n = 1'b1; b_n = 1'b1; step(10);
  endtask

  task automatic t_r6_pulse();
    do_reset(); sel = 1'b0;
    a_n = 1'b0; b_n = 1'b0;
    step(50); check(out_n, 1'b0, "R6 pulse started");
    a_n = 1'b1; b_n = 1'b1;
    step(10); check(out_n, 1'b0, "R6 release does not cut pulse");
    step(10); check(out_n, 1'b1, "R6 pulse ends after fixed length");
  endtask

  task automatic t_r9_lockout();
    do_reset(); sel = 1'b0;
    a_n = 1'b0; b_n = 1'b0;
    step(50); check(out_n, 1'b0, "R9 first pulse");
    step(30); check(out_n, 1'b1, "R9 pulse over");
    step(150); check(out_n, 1'b1, "R9 no repeat while held");
    a_n = 1'b1; step(10);
    a_n = 1'b0;
    step(50); check(out_n, 1'b0, "R9 re-press triggers again");
    step(30); a_n = 1'b1; b_n = 1'b1; step(10);
  endtask

  task automatic t_r8_startup();
    rst = 1'b1; a_n = 1'b0; b_n = 1'b0; sel = 1'b0;
    step(3);
    rst = 1'b0;
    step(5);  check(out_n, 1'b1, "R8 quiet during start-up");
    step(40); check(out_n, 1'b1, "R8 start-up delay added to hold");
    step(20); check(out_n, 1'b0, "R8 reset after start-up plus hold");
    step(30); a_n = 1'b1; b_n = 1'b1; step(10);
  endtask

  task automatic t_r5_r7_test();
    do_reset(); tsel = 1'b1;
    ta_n = 1'b0; tb_n = 1'b0;
    step(1);  check(tout_n, 1'b1, "R5 not before sync and detect delay");
    step(11); check(tout_n, 1'b0, "R5 test-mode detect delay");
    step(100); check(tout_n, 1'b0, "R7 held while both low");
    tb_n = 1'b1;
    step(5); check(tout_n, 1'b1, "R7 ends on release");
    tb_n = 1'b0; tsel = 1'b0;
    step(35); check(tout_n, 1'b1, "R3 test inst before short hold");
    step(15); check(tout_n, 1'b0, "R3 test inst after short hold");
    ta_n = 1'b1; tb_n = 1'b1; step(10);
  endtask

  initial begin
    t_r1_idle();
    t_r3_short();
    t_r4_long();
    t_r2_abort();
    t_r6_pulse();
    t_r9_lockout();
    t_r8_startup();
    t_r5_r7_test();
    $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
    $finish;
  end

  initial begin
    #(200_000 * 10);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
    $finish;
  end

endmodule